// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This combinational unit carries out the second-byte operations of an 8-bit accumulator CPU's extended opcode page. It takes one 8-bit operand, the opcode byte that follows the page prefix, and the current flag byte. It returns the new operand value, the new flag byte, and a write-enable that tells the register file or memory path whether to store the value.

The opcode byte holds two fields. The two top bits choose the operation group: shift/rotate, bit test, bit clear or bit set. The three middle bits choose either one of eight shift kinds or a bit index. Eight shift kinds are supported, including the left shift that fills bit 0 with a one. Register selection, memory access, timing and prefix detection are handled elsewhere.

Top module: `cb_rsb_unit`

## Requirements
- R1: `op_byte[7:6]` picks the group: 00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set. `op_byte[5:3]` picks either the shift kind (0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SLL, 7 SRL) or the bit index n.
- R2: RLC rotates left, so old bit 7 goes to both bit 0 and the carry. RRC rotates right, so old bit 0 goes to both bit 7 and the carry.
- R3: RL shifts left with `flags_in[0]` entering bit 0, and old bit 7 becomes the carry. RR shifts right with `flags_in[0]` entering bit 7, and old bit 0 becomes the carry.
- R4: SLA shifts left with a zero into bit 0. SRA shifts right and keeps bit 7. SRL shifts right with a zero into bit 7. SLA takes its carry from old bit 7; SRA and SRL take theirs from old bit 0.
- R5: SLL shifts left, forces bit 0 to 1, and sends old bit 7 to the carry.
- R6: After a shift or rotate, `flags_out` holds the following. Bit 0 is the carry out. Bit 1 and bit 4 are 0. Bit 2 is parity. Bits 3, 5 and 7 copy the same bits of the result. Bit 6 is 1 when the result is zero.
- R7: The parity flag (bit 2) is 1 when the value it describes has an even number of one bits.
- R8: For a bit test, `result` equals `operand` and flag bit 0 keeps `flags_in[0]`. Bits 6 and 2 are both the inverse of operand bit n. Bit 4 is 1 and bit 1 is 0. Bit 7 is 1 only when n = 7 and that bit is set. Bits 5 and 3 copy operand bits 5 and 3.
- R9: Bit clear drives bit n of the result to 0, and bit set drives it to 1. All other bits pass through unchanged. `flags_out` equals `flags_in` for both.
- R10: `wr_en` is 0 for a bit test and 1 for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_byte | input | 8 | Opcode byte that follows the prefix |
| operand | input | 8 | Value to operate on |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | New operand value |
| flags_out | output | 8 | New flag byte |
| wr_en | output | 1 | Store the result when 1 |

## Verification
The bench aims at the carry paths. RL and RR must take the incoming carry: a design that fed back its own edge bit instead would make RL look like RLC. SRA must keep the sign bit, and SLL must set bit 0, so a zero fill on either shows up at once. Flag layout corners are also covered: a zero result must give both Z and parity, and bit 7 set with n = 7 must give the sign flag on a bit test. A swap of Z and parity, or a sign flag that ignores n, would give a wrong flag byte. A full sweep of every opcode across edge operands and both carry values catches any decode that mislabels a group or swaps two shift kinds.

// File: rtl/cb_rsb_pkg.sv
package cb_rsb_pkg;

   localparam int FL_C  = 0;
   localparam int FL_N  = 1;
   localparam int FL_P  = 2;
   localparam int FL_X3 = 3;
   localparam int FL_H  = 4;
   localparam int FL_X5 = 5;
   localparam int FL_Z  = 6;
   localparam int FL_S  = 7;

   typedef enum logic [1:0] {
      GRP_SHIFT = 2'b00,
      GRP_TEST  = 2'b01,
      GRP_CLR   = 2'b10,
      GRP_SET   = 2'b11
   } grp_e;

   typedef enum logic [2:0] {
      SK_RLC = 3'd0,
      SK_RRC = 3'd1,
      SK_RL  = 3'd2,
      SK_RR  = 3'd3,
      SK_SLA = 3'd4,
      SK_SRA = 3'd5,
      SK_SLL = 3'd6,
      SK_SRL = 3'd7
   } shk_e;

   function automatic logic even_ones(input logic [7:0] v);
      return ~(^v);
   endfunction

endpackage

// File: rtl/cb_rsb_decode.sv
module cb_rsb_decode
   import cb_rsb_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int SEL_W = 3
) (
   input  logic [OP_W-1:0]  op_byte,
   output grp_e             grp,
   output shk_e             kind,
   output logic [SEL_W-1:0] sel,
   output logic             wr_en
);
   localparam int GRP_LSB = OP_W - 2;
   localparam int SEL_LSB = GRP_LSB - SEL_W;

   if (SEL_LSB < 0) begin : g_bad_width
      $error("opcode too narrow for its fields");
   end

   always_comb begin
      grp   = grp_e'(op_byte[OP_W-1:GRP_LSB]);
      sel   = op_byte[GRP_LSB-1:SEL_LSB];
      kind  = shk_e'(sel);
      wr_en = (grp != GRP_TEST);
   end

endmodule

// File: rtl/cb_rsb_shifter.sv
module cb_rsb_shifter
   import cb_rsb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] operand,
   input  shk_e              kind,
   input  logic              carry_in,
   output logic [DATA_W-1:0] res,
   output logic              carry_out
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("shifter needs at least two bits");
   end

   always_comb begin
      res       = operand;
      carry_out = 1'b0;
      unique case (kind)
         SK_RLC: begin res = {operand[MSB-1:0], operand[MSB]}; carry_out = operand[MSB]; end
         SK_RRC: begin res = {operand[0], operand[MSB:1]};     carry_out = operand[0];   end
         SK_RL:  begin res = {operand[MSB-1:0], carry_in};     carry_out = operand[MSB]; end
         SK_RR:  begin res = {carry_in, operand[MSB:1]};       carry_out = operand[0];   end
         SK_SLA: begin res = {operand[MSB-1:0], 1'b0};         carry_out = operand[MSB]; end
         SK_SRA: begin res = {operand[MSB], operand[MSB:1]};   carry_out = operand[0];   end
         SK_SLL: begin res = {operand[MSB-1:0], 1'b1};         carry_out = operand[MSB]; end
         SK_SRL: begin res = {1'b0, operand[MSB:1]};           carry_out = operand[0];   end
         default: begin res = operand; carry_out = 1'b0; end
      endcase
   end

   always_comb begin
      if (kind == SK_RLC || kind == SK_RRC)
         AST_ROT_KEEPS_ONES: assert ($countones(res) == $countones(operand)); // R2
      if (kind == SK_SRA)
         AST_SRA_SIGN_HELD: assert (res[MSB] == operand[MSB]); // R4
   end

endmodule

// File: rtl/cb_rsb_flaggen.sv
module cb_rsb_flaggen
   import cb_rsb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              carry,
   output logic [7:0]        flags
);
   if (DATA_W != 8) begin : g_bad_width
      $error("flag layout assumes an 8-bit value");
   end

   always_comb begin
      flags        = 8'h00;
      flags[FL_C]  = carry;
      flags[FL_N]  = 1'b0;
      flags[FL_P]  = even_ones(res);
      flags[FL_X3] = res[FL_X3];
      flags[FL_H]  = 1'b0;
      flags[FL_X5] = res[FL_X5];
      flags[FL_Z]  = (res == '0);
      flags[FL_S]  = res[FL_S];
   end

endmodule

// File: rtl/cb_rsb_bitop.sv
module cb_rsb_bitop
   import cb_rsb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [SEL_W-1:0]  sel,
   input  grp_e              grp,
   input  logic [7:0]        flags_in,
   output logic [DATA_W-1:0] res,
   output logic [7:0]        flags
);
   localparam int TOP_IDX = DATA_W - 1;

   if ((1 << SEL_W) != DATA_W) begin : g_bad_width
      $error("bit index width does not match data width");
   end

   logic [DATA_W-1:0] mask;
   logic              hit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (sel == SEL_W'(i));
   end

   assign hit = |(operand & mask);

   always_comb begin
      res   = operand;
      flags = flags_in;
      unique case (grp)
         GRP_CLR: res = operand & ~mask;
         GRP_SET: res = operand | mask;
         GRP_TEST: begin
            flags        = 8'h00;
            flags[FL_C]  = flags_in[FL_C];
            flags[FL_N]  = 1'b0;
            flags[FL_P]  = ~hit;
            flags[FL_X3] = operand[FL_X3];
            flags[FL_H]  = 1'b1;
            flags[FL_X5] = operand[FL_X5];
            flags[FL_Z]  = ~hit;
            flags[FL_S]  = hit && (sel == SEL_W'(TOP_IDX));
         end
         default: res = operand;
      endcase
   end

   always_comb begin
      if (grp == GRP_CLR || grp == GRP_SET)
         AST_ONE_BIT_TOUCHED: assert ($countones(res ^ operand) <= 1); // R9
      if (grp == GRP_CLR)
         AST_CLR_TARGET_LOW: assert ((res & mask) == '0); // R9
   end

endmodule

// File: rtl/cb_rsb_unit.sv
module cb_rsb_unit
   import cb_rsb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OP_W   = 8
) (
   input  logic [OP_W-1:0]   op_byte,
   input  logic [DATA_W-1:0] operand,
   input  logic [7:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [7:0]        flags_out,
   output logic              wr_en
);
   localparam int SEL_W = $clog2(DATA_W);

   if (DATA_W != 8 || OP_W != 8) begin : g_bad_params
      $error("unit is defined for an 8-bit operand and opcode");
   end

   grp_e              grp;
   shk_e              kind;
   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] sh_res, bt_res;
   logic              sh_carry;
   logic [7:0]        sh_flags, bt_flags;

   cb_rsb_decode #(.OP_W(OP_W), .SEL_W(SEL_W)) u_dec (
      .op_byte (op_byte),
      .grp     (grp),
      .kind    (kind),
      .sel     (sel),
      .wr_en   (wr_en)
   );

   cb_rsb_shifter #(.DATA_W(DATA_W)) u_shf (
      .operand   (operand),
      .kind      (kind),
      .carry_in  (flags_in[FL_C]),
      .res       (sh_res),
      .carry_out (sh_carry)
   );

   cb_rsb_flaggen #(.DATA_W(DATA_W)) u_flg (
      .res   (sh_res),
      .carry (sh_carry),
      .flags (sh_flags)
   );

   cb_rsb_bitop #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bit (
      .operand  (operand),
      .sel      (sel),
      .grp      (grp),
      .flags_in (flags_in),
      .res      (bt_res),
      .flags    (bt_flags)
   );

   always_comb begin
      if (grp == GRP_SHIFT) begin
         result    = sh_res;
         flags_out = sh_flags;
      end else begin
         result    = bt_res;
         flags_out = bt_flags;
      end
   end

   always_comb begin
      if (!wr_en)
         AST_TEST_NO_CHANGE: assert (result == operand); // R8
      if (op_byte[7:6] == 2'b01)
         AST_TEST_CARRY_KEPT: assert (flags_out[FL_C] == flags_in[FL_C]); // R8
      if (op_byte[7] == 1'b1)
         AST_CLRSET_FLAGS_KEPT: assert (flags_out == flags_in); // R9
      if (op_byte[7:6] == 2'b00)
         AST_SHIFT_ZERO_FLAG: assert (flags_out[FL_Z] == (result == '0)); // R6
      if (op_byte[7:6] == 2'b00)
         AST_SHIFT_SPARE_LOW: assert (flags_out[FL_H] == 1'b0 && flags_out[FL_N] == 1'b0); // R6
      AST_WRITE_GROUP: assert (wr_en == (op_byte[7:6] != 2'b01)); // R10
   end

endmodule

// File: tb/tb_cb_rsb_unit.sv
module tb_cb_rsb_unit;

   logic       clk = 1'b0;
   logic [7:0] op_byte, operand, flags_in;
   logic [7:0] result, flags_out;
   logic       wr_en;
   int         n_chk = 0;
   int         n_bad = 0;
   int         cyc = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   cb_rsb_unit dut (
      .op_byte   (op_byte),
      .operand   (operand),
      .flags_in  (flags_in),
      .result    (result),
      .flags_out (flags_out),
      .wr_en     (wr_en)
   );

   function automatic void model(input logic [7:0] op, input logic [7:0] a,
                                 input logic [7:0] f, output logic [7:0] r,
                                 output logic [7:0] fo, output logic we);
      logic c;
      logic [2:0] n = op[5:3];
      r = a; fo = f; we = 1'b1; c = 1'b0;
      case (op[7:6])
         2'b00: begin
            case (n)
               3'd0: begin c = a[7]; r = {a[6:0], a[7]}; end
               3'd1: begin c = a[0]; r = {a[0], a[7:1]}; end
               3'd2: begin c = a[7]; r = {a[6:0], f[0]}; end
               3'd3: begin c = a[0]; r = {f[0], a[7:1]}; end
               3'd4: begin c = a[7]; r = {a[6:0], 1'b0}; end
               3'd5: begin c = a[0]; r = {a[7], a[7:1]}; end
               3'd6: begin c = a[7]; r = {a[6:0], 1'b1}; end
               default: begin c = a[0]; r = {1'b0, a[7:1]}; end
            endcase
            fo = {r[7], r == 8'h00, r[5], 1'b0, r[3], ($countones(r) % 2) == 0, 1'b0, c};
         end
         2'b01: begin
            we = 1'b0;
            fo = {(n == 3'd7) && a[n], ~a[n], a[5], 1'b1, a[3], ~a[n], 1'b0, f[0]};
         end
         2'b10: r[n] = 1'b0;
         default: r[n] = 1'b1;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] op, input logic [7:0] a,
                        input logic [7:0] f, input logic [7:0] er,
                        input logic [7:0] ef, input logic ew);
      op_byte = op; operand = a; flags_in = f;
      #1;
      n_chk++;
      if (result !== er || flags_out !== ef || wr_en !== ew) begin
         n_bad++;
         $display("FAIL %s op=%02h a=%02h f=%02h: got r=%02h f=%02h we=%0b, want r=%02h f=%02h we=%0b",
                  req, op, a, f, result, flags_out, wr_en, er, ef, ew);
      end
      #1;
   endtask

   task automatic t_idle;        // R1 R6 R7: all-zero inputs decode as RLC of zero
      check("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h44, 1'b1);
   endtask

   task automatic t_rotates;
      check("R2", 8'h00, 8'h81, 8'h00, 8'h03, 8'h05, 1'b1);
      check("R2", 8'h08, 8'h01, 8'h00, 8'h80, 8'h81, 1'b1);
      check("R3", 8'h10, 8'h80, 8'h01, 8'h01, 8'h01, 1'b1);
      check("R3", 8'h18, 8'h01, 8'h00, 8'h00, 8'h45, 1'b1);
      check("R3", 8'h18, 8'h00, 8'h01, 8'h80, 8'h80, 1'b1);
   endtask

   task automatic t_shifts;
      check("R4", 8'h20, 8'hFF, 8'h00, 8'hFE, 8'hA9, 1'b1);
      check("R4", 8'h28, 8'h81, 8'h00, 8'hC0, 8'h85, 1'b1);
      check("R4", 8'h38, 8'h81, 8'h01, 8'h40, 8'h01, 1'b1);
      check("R5", 8'h30, 8'h80, 8'h00, 8'h01, 8'h01, 1'b1);
      check("R5", 8'h30, 8'h00, 8'hFF, 8'h01, 8'h00, 1'b1);
   endtask

   task automatic t_flags;       // R6 R7: copied result bits and parity
      check("R6", 8'h38, 8'h50, 8'hFF, 8'h28, 8'h2C, 1'b1);
      check("R7", 8'h00, 8'h07, 8'h00, 8'h0E, 8'h08, 1'b1);
   endtask

   task automatic t_test;
      check("R8", 8'h78, 8'h80, 8'h01, 8'h80, 8'h91, 1'b0);
      check("R8", 8'h40, 8'h28, 8'hFE, 8'h28, 8'h7C, 1'b0);
      check("R10", 8'h70, 8'h40, 8'h00, 8'h40, 8'h10, 1'b0);
   endtask

   task automatic t_clrset;
      check("R9", 8'h98, 8'hFF, 8'h5A, 8'hF7, 8'h5A, 1'b1);
      check("R9", 8'hF0, 8'h00, 8'hA5, 8'h40, 8'hA5, 1'b1);
      check("R10", 8'hC0, 8'h01, 8'h00, 8'h01, 8'h00, 1'b1);
   endtask

   task automatic t_sweep;       // R1: every opcode against the requirement model
      logic [7:0] vals [6] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A, 8'hA5};
      for (int op = 0; op < 256; op++)
         for (int v = 0; v < 6; v++)
            for (int cf = 0; cf < 2; cf++) begin
               logic [7:0] er, ef, fi;
               logic ew;
               fi = (cf != 0) ? 8'hD7 : 8'h28;
               model(8'(op), vals[v], fi, er, ef, ew);
               check("R1", 8'(op), vals[v], fi, er, ef, ew);
            end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got running, want finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      op_byte = '0; operand = '0; flags_in = '0;
      #3;
      t_idle();
      t_rotates();
      t_shifts();
      t_flags();
      t_test();
      t_clrset();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule